// File: doc/BRIEF.md
# Serial Target with Per-Frame Clock Mode Detection

This block is the receive and transmit front end of a serial peripheral interface target. An external host owns the serial clock. The block only observes that clock and never drives it. Each frame works the same way. Chip select falls. The block reads the idle level of the serial clock at that moment and picks one of two timing schemes for the whole frame: clock idling low (mode 0) or clock idling high (mode 3). It then shifts incoming data into 16-bit words. It shifts a parallel word from the core out on the serial output, and gives the core a one-cycle strobe for each completed word.

All serial inputs pass through two-flop synchronizers into the system clock domain, and edges are found there. For this reason the system clock must run at least four times faster than the serial clock. When parameter `SINGLE_WIRE` is set, the block serves a shared data pin. It then enables its output only while the core signals an output phase, and leaves the pin released at all other times. A pad outside the block combines the output, the enable and the input into one pin.

Top module: `spi_target_automode`

## Requirements
- R1: After reset, `serOutEn` is 0, `rxValid` is 0, `rxWord` is 0 and `modeHigh` is 0.
- R2: When chip select falls, `modeHigh` takes the serial clock level (0 = clock idles low, mode 0; 1 = clock idles high, mode 3). It keeps that value until the next falling edge of chip select, including across the idle time between frames.
- R3: Serial input is sampled on each rising clock edge, most significant bit first. After 16 rising edges, `rxWord[15]` holds the first bit sampled and `rxWord[0]` holds the last.
- R4: `rxValid` is high for exactly one system clock for each completed 16-bit word. `rxWord` changes only in that cycle.
- R5: `serOut` shows `txWord[15]` as soon as chip select is active. Each following falling clock edge moves to the next lower bit. In mode 3, the leading falling edge of a frame does not advance the output.
- R6: Within one frame, words follow each other with no gap. The falling edge after the 16th rising edge reloads `txWord`, and reception of the next word continues.
- R7: Deasserting chip select part-way through a word discards that word. No strobe is given, `rxWord` keeps its previous value, and the next frame starts again at bit 15.
- R8: With `SINGLE_WIRE` = 0, `serOutEn` is 1 while the synchronized chip select is active and 0 otherwise.
- R9: With `SINGLE_WIRE` = 1, `serOutEn` is 1 only while chip select is active and `txPhase` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from the host |
| csNIn | input | 1 | Chip select, active low |
| sdiIn | input | 1 | Serial data from the host |
| txWord | input | 16 | Word from the core to shift out |
| txPhase | input | 1 | Output phase indication (used only in single-wire build) |
| serOut | output | 1 | Serial data toward the host |
| serOutEn | output | 1 | Output enable for the serial data pad |
| rxWord | output | 16 | Last completed received word |
| rxValid | output | 1 | One-cycle strobe marking a new `rxWord` |
| modeHigh | output | 1 | Clock mode latched at frame start (1 = mode 3) |

## Verification
A walking-one transmit pattern is run against its bitwise complement on the receive side, in both clock modes. Each bit position is therefore seen as a lone 1 in one direction and a lone 0 in the other. This separates shift-direction and bit-order faults from stuck bits, and separates the mode-3 leading-edge skip from an off-by-one shift. Two-word frames use distinct words in each half, to show that the reload at the word boundary takes the new core word. Frames truncated after 7 bits, each followed by a full frame, show that the partial word is dropped and that the bit counter restarts. A second instance, built for the shared pin, is driven with the output phase low and then high during an active frame.

// File: rtl/spi_at_pkg.sv
package spi_at_pkg;
  typedef struct packed {
    logic loadTx;
    logic shiftOut;
    logic sampleIn;
    logic wordDone;
  } spiStrobe_t;
endpackage

// File: rtl/spi_at_sync.sv
module spi_at_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= RST_VAL;
      syncOut <= RST_VAL;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/spi_at_ctrl.sv
module spi_at_ctrl
  import spi_at_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkSync,
  input  logic       csNSync,
  output spiStrobe_t stb,
  output logic       modeHigh
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic             sclkPrev;
  logic             csNPrev;
  logic             skipFall;
  logic [CNT_W-1:0] bitCnt;
  logic             clkRise;
  logic             clkFall;
  logic             frameStart;
  logic             inFrame;
  logic             outEdge;

  assign clkRise    = sclkSync & ~sclkPrev;
  assign clkFall    = ~sclkSync & sclkPrev;
  assign frameStart = ~csNSync & csNPrev;
  assign inFrame    = ~csNSync & ~frameStart;
  assign outEdge    = inFrame & clkFall & ~skipFall;

  always_comb begin
    stb.sampleIn = inFrame & clkRise;
    stb.wordDone = inFrame & clkRise & (bitCnt == LAST_BIT);
    stb.loadTx   = frameStart | (outEdge & (bitCnt == '0));
    stb.shiftOut = outEdge & (bitCnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csNPrev  <= 1'b1;
      skipFall <= 1'b0;
      bitCnt   <= '0;
      modeHigh <= 1'b0;
    end else begin
      sclkPrev <= sclkSync;
      csNPrev  <= csNSync;
      if (csNSync) begin
        bitCnt   <= '0;
        skipFall <= 1'b0;
      end else if (frameStart) begin
        modeHigh <= sclkSync;
        skipFall <= sclkSync;
        bitCnt   <= '0;
      end else begin
        if (clkRise) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
        if (clkFall) skipFall <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_at_datapath.sv
module spi_at_datapath
  import spi_at_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        stb,
  input  logic              sdiSync,
  input  logic [WORD_W-1:0] txWord,
  output logic              serOut,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid
);
  logic [WORD_W-1:0] shiftIn;
  logic [WORD_W-1:0] shiftOut;

  assign serOut = shiftOut[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn  <= '0;
      shiftOut <= '0;
      rxWord   <= '0;
      rxValid  <= 1'b0;
    end else begin
      if (stb.sampleIn) shiftIn <= {shiftIn[WORD_W-2:0], sdiSync};
      if (stb.loadTx) shiftOut <= txWord;
      else if (stb.shiftOut) shiftOut <= {shiftOut[WORD_W-2:0], 1'b0};
      rxValid <= stb.wordDone;
      if (stb.wordDone) rxWord <= {shiftIn[WORD_W-2:0], sdiSync};
    end
  end
endmodule

// File: rtl/spi_target_automode.sv
module spi_target_automode
  import spi_at_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter bit SINGLE_WIRE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csNIn,
  input  logic              sdiIn,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txPhase,
  output logic              serOut,
  output logic              serOutEn,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              modeHigh
);
  logic [2:0] syncVec;
  logic       sclkSync;
  logic       csNSync;
  logic       sdiSync;
  spiStrobe_t stb;

  spi_at_sync #(.WIDTH(3), .RST_VAL(3'b010)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({sclkIn, csNIn, sdiIn}),
    .syncOut(syncVec)
  );
  assign {sclkSync, csNSync, sdiSync} = syncVec;

  spi_at_ctrl #(.WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .sclkSync(sclkSync), .csNSync(csNSync),
    .stb(stb), .modeHigh(modeHigh)
  );

  spi_at_datapath #(.WORD_W(WORD_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiSync(sdiSync),
    .txWord(txWord), .serOut(serOut), .rxWord(rxWord), .rxValid(rxValid)
  );

  generate
    if (SINGLE_WIRE) begin : gShared
      assign serOutEn = ~csNSync & txPhase;
    end else begin : gFour
      logic unusedPhase;
      assign unusedPhase = txPhase;
      assign serOutEn    = ~csNSync;
    end
  endgenerate
endmodule

// File: rtl/spi_target_automode_chk.sv
module spi_target_automode_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              csNSync,
  input logic              serOut,
  input logic              serOutEn,
  input logic [WORD_W-1:0] rxWord,
  input logic              rxValid,
  input logic              modeHigh
);
  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_rx_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxWord));

  assert_no_strobe_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !$past(csNSync));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!csNSync && !$past(csNSync) && !$past(csNSync, 2)) |-> $stable(modeHigh));

  assert_mode_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(csNSync) |-> $stable(modeHigh));

  assert_oe_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    csNSync |-> !serOutEn);

  assert_out_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (csNSync && $past(csNSync)) |-> $stable(serOut));
endmodule

bind spi_target_automode spi_target_automode_chk #(.WORD_W(WORD_W)) uChk (
  .clk(clk), .rstN(rstN), .csNSync(csNSync), .serOut(serOut),
  .serOutEn(serOutEn), .rxWord(rxWord), .rxValid(rxValid), .modeHigh(modeHigh)
);

// File: tb/sim_spi_target_automode.sv
module sim_spi_target_automode;
  localparam int H = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, sclk, csN, mosi, phase;
  logic [15:0] txWord;
  logic        serOut0, serOutEn0, rxValid0, modeHigh0;
  logic [15:0] rxWord0;
  logic        serOut1, serOutEn1, rxValid1, modeHigh1;
  logic [15:0] rxWord1;

  int checks = 0;
  int fails = 0;
  int vCount = 0;
  logic [15:0] lastRx = '0;
  bit done = 1'b0;

  spi_target_automode u0 (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .csNIn(csN), .sdiIn(mosi),
    .txWord(txWord), .txPhase(1'b0), .serOut(serOut0), .serOutEn(serOutEn0),
    .rxWord(rxWord0), .rxValid(rxValid0), .modeHigh(modeHigh0)
  );

  spi_target_automode #(.SINGLE_WIRE(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .csNIn(csN), .sdiIn(mosi),
    .txWord(txWord), .txPhase(phase), .serOut(serOut1), .serOutEn(serOutEn1),
    .rxWord(rxWord1), .rxValid(rxValid1), .modeHigh(modeHigh1)
  );

  always @(negedge clk) if (rstN && rxValid0) begin
    vCount = vCount + 1;
    lastRx = rxWord0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input bit m3, input int nbits, input logic [15:0] tA, input logic [15:0] tB,
                       input logic [15:0] rA, input logic [15:0] rB);
    int v0 = vCount;
    int bad = 0;
    int words = nbits / 16;
    logic [15:0] rxBefore = lastRx;
    logic [15:0] expRx;
    txWord = tA;
    sclk = m3;
    waitc(H);
    csN = 1'b0;
    waitc(H);
    chk(serOutEn0 == 1'b1, "R8 enable in frame", serOutEn0, 1);
    for (int k = 0; k < nbits; k++) begin
      logic [15:0] tw = (k < 16) ? tA : tB;
      logic [15:0] rw = (k < 16) ? rA : rB;
      int idx = 15 - (k % 16);
      sclk = 1'b0;
      mosi = rw[idx];
      waitc(H);
      if (serOut0 !== tw[idx]) bad++;
      if (k == 0) chk(modeHigh0 == m3, "R2 mode latch", modeHigh0, m3);
      sclk = 1'b1;
      waitc(H);
      if (k == 15) txWord = tB;
    end
    if (!m3) begin
      sclk = 1'b0;
      waitc(H);
    end
    chk(modeHigh0 == m3, "R2 mode held to frame end", modeHigh0, m3);
    csN = 1'b1;
    waitc(2 * H);
    chk(bad == 0, "R5/R6 serial output bit errors", bad, 0);
    chk(vCount - v0 == words, "R4 strobe count", vCount - v0, words);
    expRx = (words == 0) ? rxBefore : ((words == 2) ? rB : rA);
    chk(lastRx == expRx, (words == 0) ? "R7 truncated word dropped" : "R3/R6 received word",
        lastRx, expRx);
    chk(rxWord0 == expRx, "R7 rxWord held after frame", rxWord0, expRx);
    chk(serOutEn0 == 1'b0, "R8 released when idle", serOutEn0, 0);
    chk(modeHigh0 == m3, "R2 mode kept while idle", modeHigh0, m3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sclk = 1'b0; csN = 1'b1; mosi = 1'b0; phase = 1'b0; txWord = '0;
    waitc(5);
    rstN = 1'b1;
    waitc(2);
    chk(serOutEn0 == 0, "R1 reset enable", serOutEn0, 0);
    chk(rxValid0 == 0, "R1 reset strobe", rxValid0, 0);
    chk(rxWord0 == 0, "R1 reset word", rxWord0, 0);
    chk(modeHigh0 == 0, "R1 reset mode", modeHigh0, 0);

    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 16; b++) begin
        logic [15:0] walk = 16'h1 << b;
        frame(m[0], 16, walk, 16'h0, ~walk, 16'h0);
      end
      frame(m[0], 16, 16'hA5C3, 16'h0, 16'h5AF0, 16'h0);
      frame(m[0], 32, 16'h8001, 16'h7E3C, 16'h1234, 16'hFEDC);
      frame(m[0], 7, 16'hFFFF, 16'h0, 16'h0F0F, 16'h0);
      frame(m[0], 16, 16'hC3A5, 16'h0, 16'h9669, 16'h0);
    end
    frame(1'b0, 16, 16'h0F0F, 16'h0, 16'hAAAA, 16'h0);
    frame(1'b1, 16, 16'hF0F0, 16'h0, 16'h5555, 16'h0);

    phase = 1'b0;
    sclk = 1'b0;
    waitc(H);
    csN = 1'b0;
    waitc(H);
    chk(serOutEn1 == 0, "R9 released outside output phase", serOutEn1, 0);
    phase = 1'b1;
    waitc(2);
    chk(serOutEn1 == 1, "R9 driven in output phase", serOutEn1, 1);
    csN = 1'b1;
    waitc(H);
    chk(serOutEn1 == 0, "R9 released when deselected", serOutEn1, 0);
    phase = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule